// File: doc/BRIEF.md
# PWM Output Protection Stage

This block sits between a dead-time generator and the output pins of a two-channel half-bridge driver. Each channel receives a complementary high/low PWM pair. The block applies a separate polarity inversion to each of the four outputs and passes the result to the pins.

Three kinds of fault can interrupt this path: overvoltage and undervoltage, one comparator of each per channel, and one overcurrent comparator shared by both channels. Each source has a protection enable. When an enabled source is active, the affected pins are driven to a programmed safe level. Normal PWM resumes without software action once the source goes quiet.

Every enabled fault also leaves a sticky flag behind, and any raised flag asserts the interrupt request. Software clears a flag by writing one to it. The fault comparators are asynchronous, so each one passes through a synchronizer before the block uses it.

Top module: `pwm_out_guard`

## Requirements
- R1: After reset, all flags are zero, `irq_o` is low, and each output pin equals its PWM input while all control inputs are zero.
- R2: While a channel has no active fault, `out_hi_o[c]` equals `pwm_hi_i[c] XOR inv_hi_i[c]`, and `out_lo_o[c]` equals `pwm_lo_i[c] XOR inv_lo_i[c]`.
- R3: A fault source whose enable is low has no effect on the pins or the flags. `en_vp_i[c]` enables both the overvoltage and the undervoltage source of channel c, and `en_oc_i` enables the overcurrent source.
- R4: Overvoltage and undervoltage source c affect only channel c. Overcurrent affects every channel.
- R5: While a channel is faulted, its high pin equals `safe_hi_i[c]` and its low pin equals `safe_lo_i[c]`. This holds regardless of the PWM and invert inputs.
- R6: Suppose a fault input rises before clock edge k. The affected pins are still unforced after edge k and are forced after edge k+1.
- R7: Suppose a fault input falls before edge k. The pins stay forced after edge k and follow R2 again after edge k+1, with no software action.
- R8: Flag bit layout: [2c] is overvoltage c, [2c+1] is undervoltage c, and [2·N_CH] is overcurrent. A flag sets on the rising edge of its enabled, synchronized source, one edge after the pins are forced. It stays set after the fault clears.
- R9: A one in `clr_i[b]` clears flag b at the next edge. `irq_o` is high exactly when at least one flag is set.
- R10: If a flag's set event and a write-one clear fall in the same cycle, the set wins and the flag stays one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi_i | input | N_CH | High-side PWM per channel |
| pwm_lo_i | input | N_CH | Low-side PWM per channel |
| ovp_i | input | N_CH | Overvoltage comparator per channel (async) |
| uvp_i | input | N_CH | Undervoltage comparator per channel (async) |
| ocp_i | input | 1 | Overcurrent comparator (async) |
| en_vp_i | input | N_CH | Voltage-protection enable per channel |
| en_oc_i | input | 1 | Overcurrent-protection enable |
| inv_hi_i | input | N_CH | High-side invert per channel |
| inv_lo_i | input | N_CH | Low-side invert per channel |
| safe_hi_i | input | N_CH | High-side forced level per channel |
| safe_lo_i | input | N_CH | Low-side forced level per channel |
| clr_i | input | 2·N_CH+1 | Write-one-to-clear for the flags |
| out_hi_o | output | N_CH | High-side pin per channel |
| out_lo_o | output | N_CH | Low-side pin per channel |
| flags_o | output | 2·N_CH+1 | Sticky fault flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can fall in the same cycle: a flag being set by a fresh synchronized fault edge, and software clearing that same flag by writing one. The bench raises an undervoltage input and counts the synchronizer edges. It then pulses the matching clear bit in exactly the cycle in which the set event is pending, and it expects the flag to read one afterwards. A later clear, made while the fault level is still present, must then remove the flag, because no new edge occurs.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

    // Pair of pin-level values for one channel
    typedef struct packed {
        logic hi;
        logic lo;
    } pin_pair_t;

    // Per-output configuration
    typedef struct packed {
        logic inv;
        logic safe;
    } out_cfg_t;

    // Flag layout: [2c] overvoltage c, [2c+1] undervoltage c, [2*n_ch] overcurrent
    function automatic int ov_bit(input int ch);
        return 2 * ch;
    endfunction

    function automatic int uv_bit(input int ch);
        return 2 * ch + 1;
    endfunction

    function automatic int oc_bit(input int n_ch);
        return 2 * n_ch;
    endfunction

    function automatic logic drive_pin(input logic pwm, input out_cfg_t cfg, input logic fault);
        logic pol;
        pol = pwm ^ cfg.inv;
        return fault ? cfg.safe : pol;
    endfunction

endpackage

// File: rtl/pwm_fault_sync.sv
module pwm_fault_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pwm_fault_route.sv
module pwm_fault_route
    import pwm_guard_pkg::*;
#(
    parameter int N_CH = 2,
    localparam int SRC_N = 2 * N_CH + 1
) (
    input  logic [SRC_N-1:0] src_sync_i,
    input  logic [N_CH-1:0]  en_vp_i,
    input  logic             en_oc_i,
    output logic [SRC_N-1:0] src_gated_o,
    output logic [N_CH-1:0]  ch_fault_o
);
    logic oc_gated;

    assign oc_gated = src_sync_i[oc_bit(N_CH)] & en_oc_i;
    assign src_gated_o[oc_bit(N_CH)] = oc_gated;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign src_gated_o[ov_bit(c)] = src_sync_i[ov_bit(c)] & en_vp_i[c];
        assign src_gated_o[uv_bit(c)] = src_sync_i[uv_bit(c)] & en_vp_i[c];
        assign ch_fault_o[c] = src_gated_o[ov_bit(c)] | src_gated_o[uv_bit(c)] | oc_gated;
    end
endmodule

// File: rtl/pwm_fault_flags.sv
module pwm_fault_flags #(
    parameter int SRC_N = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_i,
    input  logic [SRC_N-1:0] clr_i,
    output logic [SRC_N-1:0] flags_o,
    output logic             irq_o
);
    logic [SRC_N-1:0] src_q;
    logic [SRC_N-1:0] rise;

    assign rise = src_i & ~src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            flags_o <= '0;
        end else begin
            src_q   <= src_i;
            flags_o <= (flags_o & ~clr_i) | rise;
        end
    end

    assign irq_o = |flags_o;

    for (genvar b = 0; b < SRC_N; b++) begin : g_chk
        // R8
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            rise[b] |=> flags_o[b]);
        // R9
        flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[b] && !rise[b]) |=> !flags_o[b]);
        // R8
        flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (flags_o[b] && !clr_i[b]) |=> flags_o[b]);
    end

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(|rise));
endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan
    import pwm_guard_pkg::*;
(
    input  pin_pair_t pwm_i,
    input  out_cfg_t  cfg_hi_i,
    input  out_cfg_t  cfg_lo_i,
    input  logic      fault_i,
    output pin_pair_t pin_o
);
    always_comb begin
        pin_o.hi = drive_pin(pwm_i.hi, cfg_hi_i, fault_i);
        pin_o.lo = drive_pin(pwm_i.lo, cfg_lo_i, fault_i);
    end
endmodule

// File: rtl/pwm_out_guard.sv
module pwm_out_guard
    import pwm_guard_pkg::*;
#(
    parameter int N_CH    = 2,
    parameter int SYNC_N  = 2,
    localparam int SRC_N  = 2 * N_CH + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CH-1:0]  pwm_hi_i,
    input  logic [N_CH-1:0]  pwm_lo_i,
    input  logic [N_CH-1:0]  ovp_i,
    input  logic [N_CH-1:0]  uvp_i,
    input  logic             ocp_i,
    input  logic [N_CH-1:0]  en_vp_i,
    input  logic             en_oc_i,
    input  logic [N_CH-1:0]  inv_hi_i,
    input  logic [N_CH-1:0]  inv_lo_i,
    input  logic [N_CH-1:0]  safe_hi_i,
    input  logic [N_CH-1:0]  safe_lo_i,
    input  logic [SRC_N-1:0] clr_i,
    output logic [N_CH-1:0]  out_hi_o,
    output logic [N_CH-1:0]  out_lo_o,
    output logic [SRC_N-1:0] flags_o,
    output logic             irq_o
);
    logic [SRC_N-1:0] src_raw;
    logic [SRC_N-1:0] src_sync;
    logic [SRC_N-1:0] src_gated;
    logic [N_CH-1:0]  ch_fault;

    assign src_raw[oc_bit(N_CH)] = ocp_i;
    for (genvar c = 0; c < N_CH; c++) begin : g_pack
        assign src_raw[ov_bit(c)] = ovp_i[c];
        assign src_raw[uv_bit(c)] = uvp_i[c];
    end

    pwm_fault_sync #(.W(SRC_N), .STAGES(SYNC_N)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(src_raw),
        .sync_o (src_sync)
    );

    pwm_fault_route #(.N_CH(N_CH)) i_route (
        .src_sync_i (src_sync),
        .en_vp_i    (en_vp_i),
        .en_oc_i    (en_oc_i),
        .src_gated_o(src_gated),
        .ch_fault_o (ch_fault)
    );

    pwm_fault_flags #(.SRC_N(SRC_N)) i_flags (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_gated),
        .clr_i  (clr_i),
        .flags_o(flags_o),
        .irq_o  (irq_o)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        pin_pair_t pwm_pair;
        pin_pair_t pin_pair;
        out_cfg_t  cfg_hi;
        out_cfg_t  cfg_lo;

        assign pwm_pair.hi = pwm_hi_i[c];
        assign pwm_pair.lo = pwm_lo_i[c];
        assign cfg_hi.inv  = inv_hi_i[c];
        assign cfg_hi.safe = safe_hi_i[c];
        assign cfg_lo.inv  = inv_lo_i[c];
        assign cfg_lo.safe = safe_lo_i[c];

        pwm_out_chan i_chan (
            .pwm_i   (pwm_pair),
            .cfg_hi_i(cfg_hi),
            .cfg_lo_i(cfg_lo),
            .fault_i (ch_fault[c]),
            .pin_o   (pin_pair)
        );

        assign out_hi_o[c] = pin_pair.hi;
        assign out_lo_o[c] = pin_pair.lo;

        // R5
        forced_level_chk: assert property (@(posedge clk) disable iff (rst)
            ch_fault[c] |-> (out_hi_o[c] == safe_hi_i[c] && out_lo_o[c] == safe_lo_i[c]));
        // R2
        normal_path_chk: assert property (@(posedge clk) disable iff (rst)
            !ch_fault[c] |-> (out_hi_o[c] == (pwm_hi_i[c] ^ inv_hi_i[c]) &&
                              out_lo_o[c] == (pwm_lo_i[c] ^ inv_lo_i[c])));
        // R3
        vp_masked_chk: assert property (@(posedge clk) disable iff (rst)
            !en_vp_i[c] |=> !$rose(flags_o[ov_bit(c)]) && !$rose(flags_o[uv_bit(c)]));
    end

    // R3
    oc_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !en_oc_i |=> !$rose(flags_o[oc_bit(N_CH)]));
endmodule

// File: tb/test_pwm_out_guard.sv
module test_pwm_out_guard;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH  = 2;
    localparam int SRC_N = 2 * N_CH + 1;

    typedef struct {
        logic [N_CH-1:0]  hi;
        logic [N_CH-1:0]  lo;
        logic [SRC_N-1:0] flags;
        logic             irq;
        string            req;
    } exp_t;

    logic clk = 0;
    logic rst = 1;
    logic [N_CH-1:0]  pwm_hi = '0, pwm_lo = '0, ovp = '0, uvp = '0;
    logic             ocp = 0, en_oc = 0;
    logic [N_CH-1:0]  en_vp = '0, inv_hi = '0, inv_lo = '0, safe_hi = '0, safe_lo = '0;
    logic [SRC_N-1:0] clr = '0;
    logic [N_CH-1:0]  out_hi, out_lo;
    logic [SRC_N-1:0] flags;
    logic             irq;

    // bench model state
    logic [N_CH-1:0]  m_force = '0;
    logic [SRC_N-1:0] m_flags = '0;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_out_guard #(.N_CH(N_CH)) i_pwm_out_guard (
        .clk(clk), .rst(rst),
        .pwm_hi_i(pwm_hi), .pwm_lo_i(pwm_lo),
        .ovp_i(ovp), .uvp_i(uvp), .ocp_i(ocp),
        .en_vp_i(en_vp), .en_oc_i(en_oc),
        .inv_hi_i(inv_hi), .inv_lo_i(inv_lo),
        .safe_hi_i(safe_hi), .safe_lo_i(safe_lo),
        .clr_i(clr),
        .out_hi_o(out_hi), .out_lo_o(out_lo),
        .flags_o(flags), .irq_o(irq)
    );

    // driver side: push an expected item built from the bench model
    task automatic push(input string req);
        exp_t e;
        for (int c = 0; c < N_CH; c++) begin
            e.hi[c] = m_force[c] ? safe_hi[c] : (pwm_hi[c] ^ inv_hi[c]);
            e.lo[c] = m_force[c] ? safe_lo[c] : (pwm_lo[c] ^ inv_lo[c]);
        end
        e.flags = m_flags;
        e.irq   = |m_flags;
        e.req   = req;
        exp_q.push_back(e);
    endtask

    task automatic drive_slot();
        @(negedge clk); #1;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: pops and compares at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (out_hi !== e.hi || out_lo !== e.lo || flags !== e.flags || irq !== e.irq) begin
                errors++;
                $display("FAIL %s: actual hi=%b lo=%b flags=%b irq=%b expected hi=%b lo=%b flags=%b irq=%b",
                         e.req, out_hi, out_lo, flags, irq, e.hi, e.lo, e.flags, e.irq);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        edges(3);
        drive_slot(); rst = 0; pwm_hi = 2'b01; pwm_lo = 2'b10;
        edges(1); push("R1 reset state");

        // R2 pass-through and inversion, several patterns
        drive_slot(); pwm_hi = 2'b10; pwm_lo = 2'b01;
        edges(1); push("R2 pass-through");
        drive_slot(); inv_hi = 2'b11; inv_lo = 2'b01;
        edges(1); push("R2 inverted");
        drive_slot(); pwm_hi = 2'b11; pwm_lo = 2'b11; inv_lo = 2'b10;
        edges(1); push("R2 inverted pattern 2");

        // R3 masked sources
        drive_slot(); ovp = 2'b01; uvp = 2'b10; ocp = 1; safe_hi = 2'b01; safe_lo = 2'b10;
        edges(4); push("R3 disabled faults ignored");
        drive_slot(); ovp = '0; uvp = '0; ocp = 0;
        edges(3);

        // R6 latency, R4 mapping, R5 forced level over inversion
        drive_slot(); en_vp = 2'b01; ovp = 2'b01;
        edges(1); push("R6 not yet forced after first edge");
        edges(1); m_force = 2'b01; push("R6 R4 R5 channel 0 forced only");
        edges(1); m_flags[0] = 1; push("R8 overvoltage 0 flag set");
        drive_slot(); pwm_hi = 2'b00; inv_hi = 2'b01;
        edges(1); push("R5 forced regardless of pwm/inv");

        // R7 recovery
        drive_slot(); ovp = '0;
        edges(1); push("R7 still forced one edge after fall");
        edges(1); m_force = '0; push("R7 recovered, R8 flag sticky");

        // R9 clear
        drive_slot(); clr = 5'b00001;
        edges(1); m_flags[0] = 0; push("R9 write-one clear, irq low");
        drive_slot(); clr = '0;

        // R4 overcurrent hits both channels
        drive_slot(); en_oc = 1; ocp = 1; safe_hi = 2'b10; safe_lo = 2'b11;
        edges(2); m_force = 2'b11; push("R4 overcurrent forces both");
        edges(1); m_flags[4] = 1; push("R8 overcurrent flag at bit 4");
        drive_slot(); ocp = 0;
        edges(2); m_force = '0; push("R7 both recovered");
        drive_slot(); clr = 5'b10000;
        edges(1); m_flags[4] = 0; push("R9 overcurrent flag cleared");
        drive_slot(); clr = '0;

        // R10 set and clear in the same cycle
        drive_slot(); en_vp = 2'b11; uvp = 2'b10;
        edges(2); m_force = 2'b10; push("R4 undervoltage 1 forces channel 1");
        drive_slot(); clr = 5'b01000;
        edges(1); m_flags[3] = 1; push("R10 set wins over clear");
        drive_slot(); clr = '0;
        edges(1); push("R10 flag still set");
        drive_slot(); clr = 5'b01000;
        edges(1); m_flags[3] = 0; push("R9 clear with fault level still present");
        drive_slot(); clr = '0; uvp = '0;
        edges(2); m_force = '0; push("R7 channel 1 recovered");

        edges(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule